// File: doc/BRIEF.md
# Host-Side Byte Mailbox Port

This block lets an external microprocessor exchange single bytes with a local CPU over an 8-bit parallel bus. The external host uses three active-low strobes: a chip select, a read strobe and a write strobe. It runs with no clock shared with the block. A host write drops a byte into an inbound latch. A host read collects the byte that the local CPU left in an outbound latch. The block drives the data pins only while such a read is under way.

On the clocked side, the local CPU loads the outbound byte and reads the inbound byte with single-cycle strobes. It watches four status flags: inbound full, outbound full, overrun and interrupt. A port-enable input switches the external interface on. While the port is off, the pins stay released and host strobes have no effect.

Each strobe and the data lines pass through a two-flop synchronizer. A transaction opens when the synchronized chip select and strobe are both low. It closes when either of them goes high. The close is what raises the interrupt and moves the handshake flags.

Top module: `hostport_slave`

## Requirements
- R1: After synchronous reset, all four flags are 0, `ext_data_oe` is 0, and `cpu_rdata` and `ext_data_o` are 0.
- R2: While `port_en` is 0, host strobes start no transaction, `ext_data_oe` stays 0, and `in_full`, `irq` and `cpu_rdata` keep their values.
- R3: When a host write (`ext_cs_n` and `ext_wr_n` both low, then either one high) completes, the byte on `ext_data_i` appears on `cpu_rdata`, and `in_full` and `irq` are 1 by the fourth rising edge after the release.
- R4: `ext_data_oe` rises at the third rising edge after `ext_cs_n` and `ext_rd_n` are both low, and not before. While it is high, `ext_data_o` carries the outbound byte.
- R5: A `cpu_wr_out` pulse while no host read is in progress loads `cpu_wdata` into the outbound latch and sets `out_full`.
- R6: A `cpu_wr_out` pulse during a host read shows up on `ext_data_o` after that same edge, and it leaves `out_full` unchanged.
- R7: A `cpu_rd_in` pulse clears `in_full`, unless a host write completes in the same cycle.
- R8: A host write that completes while `in_full` is 1 sets the sticky `overrun` flag. If `cpu_rd_in` pulses in that same cycle, `overrun` is not set, and `in_full` ends up 1 holding the new byte.
- R9: When a host read completes, `ext_data_oe` returns to 0, `out_full` is cleared and `irq` is set.
- R10: `irq` and `overrun` stay set until a `stat_clr` pulse. If a flag-setting event falls in the same cycle as `stat_clr`, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Turns the external interface on |
| ext_cs_n | input | 1 | Host chip select, active low |
| ext_rd_n | input | 1 | Host read strobe, active low |
| ext_wr_n | input | 1 | Host write strobe, active low |
| ext_data_i | input | DATA_W | Data pins, input side |
| ext_data_o | output | DATA_W | Data pins, output side (outbound latch) |
| ext_data_oe | output | 1 | Output enable for the data pins |
| cpu_wr_out | input | 1 | Local CPU write strobe for the outbound latch |
| cpu_wdata | input | DATA_W | Local CPU write data |
| cpu_rd_in | input | 1 | Local CPU read strobe for the inbound latch |
| cpu_rdata | output | DATA_W | Inbound latch contents |
| stat_clr | input | 1 | Clears `irq` and `overrun` |
| in_full | output | 1 | Inbound byte not yet read |
| out_full | output | 1 | Outbound byte not yet collected |
| overrun | output | 1 | Inbound byte overwritten before it was read |
| irq | output | 1 | Interrupt, sticky |

## Verification
Two functions can fall in the same cycle here. The first is the completion of a host write together with a local read of the inbound latch. The second is the completion of a host transaction together with a `stat_clr` pulse. The bench releases the host strobes and counts the synchronizer edges to find the exact cycle in which the close is registered. It then lands a one-cycle `cpu_rd_in` or `stat_clr` pulse on that edge. The scoreboard then expects `in_full` held at 1 with the new byte and no overrun, and `irq` held at 1 despite the clear.

// File: rtl/hostport_pkg.sv
package hostport_pkg;
  localparam int HP_DATA_W  = 8;
  localparam int HP_STAGES  = 2;
  localparam int HP_STROBES = 2;   // index 0: read, index 1: write
  localparam int HP_IDX_RD  = 0;
  localparam int HP_IDX_WR  = 1;

  typedef struct packed {
    logic lvl;     // chip select and strobe both low, port enabled
    logic active;  // level seen at the previous edge
    logic fin;     // transaction closes this cycle
  } xact_t;
endpackage

// File: rtl/hostport_sync.sv
module hostport_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= RST_VAL;
      else if (s == 0) chain[s] <= d;
      else chain[s] <= chain[(s == 0) ? 0 : s - 1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hostport_xact.sv
module hostport_xact
  import hostport_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  logic  cs_n_s,
  input  logic  strb_n_s,
  output xact_t ev
);
  logic lvl;
  logic active_q;

  assign lvl = en & ~cs_n_s & ~strb_n_s;

  always_ff @(posedge clk) begin
    if (rst) active_q <= 1'b0;
    else     active_q <= lvl;
  end

  assign ev.lvl    = lvl;
  assign ev.active = active_q;
  assign ev.fin    = active_q & ~lvl & en;
endmodule

// File: rtl/hostport_data.sv
module hostport_data #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] pin_data_s,
  input  logic              wr_lvl,
  input  logic              wr_fin,
  input  logic              rd_lvl,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] out_byte,
  output logic [DATA_W-1:0] in_byte,
  output logic              drive_oe
);
  logic [DATA_W-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q  <= '0;
      in_byte  <= '0;
      out_byte <= '0;
      drive_oe <= 1'b0;
    end else begin
      if (wr_lvl) stage_q <= pin_data_s;
      if (wr_fin) in_byte <= stage_q;
      if (cpu_wr) out_byte <= cpu_wdata;
      drive_oe <= rd_lvl;
    end
  end
endmodule

// File: rtl/hostport_flags.sv
module hostport_flags (
  input  logic clk,
  input  logic rst,
  input  logic wr_fin,
  input  logic rd_fin,
  input  logic rd_active,
  input  logic cpu_wr,
  input  logic cpu_rd,
  input  logic clr,
  output logic in_full,
  output logic out_full,
  output logic overrun,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      in_full  <= 1'b0;
      out_full <= 1'b0;
      overrun  <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (wr_fin)      in_full <= 1'b1;
      else if (cpu_rd) in_full <= 1'b0;

      if (wr_fin && in_full && !cpu_rd) overrun <= 1'b1;
      else if (clr)                     overrun <= 1'b0;

      if (rd_fin)                     out_full <= 1'b0;
      else if (cpu_wr && !rd_active)  out_full <= 1'b1;

      if (wr_fin || rd_fin) irq <= 1'b1;
      else if (clr)         irq <= 1'b0;
    end
  end
endmodule

// File: rtl/hostport_slave.sv
module hostport_slave
  import hostport_pkg::*;
#(
  parameter int DATA_W = HP_DATA_W,
  parameter int SYNC_STAGES = HP_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              port_en,
  input  logic              ext_cs_n,
  input  logic              ext_rd_n,
  input  logic              ext_wr_n,
  input  logic [DATA_W-1:0] ext_data_i,
  output logic [DATA_W-1:0] ext_data_o,
  output logic              ext_data_oe,
  input  logic              cpu_wr_out,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_rd_in,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              stat_clr,
  output logic              in_full,
  output logic              out_full,
  output logic              overrun,
  output logic              irq
);
  localparam int SYNC_W = DATA_W + 3;
  localparam logic [SYNC_W-1:0] SYNC_RST = {3'b111, {DATA_W{1'b0}}};

  logic [SYNC_W-1:0] sync_q;
  logic              cs_n_s;
  logic [HP_STROBES-1:0] strb_n_s;
  logic [DATA_W-1:0] data_s;
  xact_t             ev [HP_STROBES];
  logic              rd_active, rd_fin, wr_fin;

  hostport_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ext_cs_n, ext_wr_n, ext_rd_n, ext_data_i}),
    .q   (sync_q)
  );

  assign cs_n_s   = sync_q[SYNC_W-1];
  assign strb_n_s = sync_q[SYNC_W-2 -: HP_STROBES];
  assign data_s   = sync_q[DATA_W-1:0];

  for (genvar k = 0; k < HP_STROBES; k++) begin : g_xact
    hostport_xact u_xact (
      .clk      (clk),
      .rst      (rst),
      .en       (port_en),
      .cs_n_s   (cs_n_s),
      .strb_n_s (strb_n_s[k]),
      .ev       (ev[k])
    );
  end

  assign rd_active = ev[HP_IDX_RD].active;
  assign rd_fin    = ev[HP_IDX_RD].fin;
  assign wr_fin    = ev[HP_IDX_WR].fin;

  hostport_data #(.DATA_W(DATA_W)) u_data (
    .clk        (clk),
    .rst        (rst),
    .pin_data_s (data_s),
    .wr_lvl     (ev[HP_IDX_WR].lvl),
    .wr_fin     (wr_fin),
    .rd_lvl     (ev[HP_IDX_RD].lvl),
    .cpu_wr     (cpu_wr_out),
    .cpu_wdata  (cpu_wdata),
    .out_byte   (ext_data_o),
    .in_byte    (cpu_rdata),
    .drive_oe   (ext_data_oe)
  );

  hostport_flags u_flags (
    .clk       (clk),
    .rst       (rst),
    .wr_fin    (wr_fin),
    .rd_fin    (rd_fin),
    .rd_active (rd_active),
    .cpu_wr    (cpu_wr_out),
    .cpu_rd    (cpu_rd_in),
    .clr       (stat_clr),
    .in_full   (in_full),
    .out_full  (out_full),
    .overrun   (overrun),
    .irq       (irq)
  );
endmodule

// File: rtl/hostport_chk.sv
module hostport_chk (
  input logic clk,
  input logic rst,
  input logic port_en,
  input logic ext_data_oe,
  input logic cpu_wr_out,
  input logic cpu_rd_in,
  input logic stat_clr,
  input logic in_full,
  input logic out_full,
  input logic overrun,
  input logic irq,
  input logic rd_active,
  input logic rd_fin,
  input logic wr_fin
);
  p_pins_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !port_en |=> !ext_data_oe);

  p_write_close_r3: assert property (@(posedge clk) disable iff (rst)
    wr_fin |=> in_full && irq);

  p_cpu_load_r5: assert property (@(posedge clk) disable iff (rst)
    cpu_wr_out && !rd_active |=> out_full);

  p_live_update_r6: assert property (@(posedge clk) disable iff (rst)
    cpu_wr_out && rd_active && !out_full |=> !out_full);

  p_read_clears_r7: assert property (@(posedge clk) disable iff (rst)
    cpu_rd_in && !wr_fin |=> !in_full);

  p_overrun_set_r8: assert property (@(posedge clk) disable iff (rst)
    wr_fin && in_full && !cpu_rd_in |=> overrun);

  p_read_close_r9: assert property (@(posedge clk) disable iff (rst)
    rd_fin |=> !out_full && irq && !ext_data_oe);

  p_irq_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    irq && !stat_clr |=> irq);

  p_ovr_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    overrun && !stat_clr |=> overrun);
endmodule

bind hostport_slave hostport_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .port_en     (port_en),
  .ext_data_oe (ext_data_oe),
  .cpu_wr_out  (cpu_wr_out),
  .cpu_rd_in   (cpu_rd_in),
  .stat_clr    (stat_clr),
  .in_full     (in_full),
  .out_full    (out_full),
  .overrun     (overrun),
  .irq         (irq),
  .rd_active   (rd_active),
  .rd_fin      (rd_fin),
  .wr_fin      (wr_fin)
);

// File: tb/hostport_slave_bench.sv
`timescale 1ns/1ps
module hostport_slave_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst, port_en, ext_cs_n, ext_rd_n, ext_wr_n;
  logic [W-1:0] ext_data_i, ext_data_o, cpu_wdata, cpu_rdata;
  logic ext_data_oe, cpu_wr_out, cpu_rd_in, stat_clr;
  logic in_full, out_full, overrun, irq;

  always #4 clk = ~clk;

  hostport_slave u_hostport_slave (
    .clk(clk), .rst(rst), .port_en(port_en),
    .ext_cs_n(ext_cs_n), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n),
    .ext_data_i(ext_data_i), .ext_data_o(ext_data_o), .ext_data_oe(ext_data_oe),
    .cpu_wr_out(cpu_wr_out), .cpu_wdata(cpu_wdata), .cpu_rd_in(cpu_rd_in),
    .cpu_rdata(cpu_rdata), .stat_clr(stat_clr),
    .in_full(in_full), .out_full(out_full), .overrun(overrun), .irq(irq)
  );

  typedef enum int {S_OE, S_DOUT, S_RDATA, S_INF, S_OUTF, S_OVR, S_IRQ} sel_t;
  typedef struct {
    string req;
    sel_t  sel;
    int    exp;
  } item_t;

  item_t q[$];
  event  go;
  int checks = 0, errors = 0;
  bit finished = 0;

  function automatic int observe(sel_t s);
    case (s)
      S_OE:    return int'(ext_data_oe);
      S_DOUT:  return int'(ext_data_o);
      S_RDATA: return int'(cpu_rdata);
      S_INF:   return int'(in_full);
      S_OUTF:  return int'(out_full);
      S_OVR:   return int'(overrun);
      default: return int'(irq);
    endcase
  endfunction

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(go);
      while (q.size() != 0) begin
        item_t it;
        int act;
        it = q.pop_front();
        act = observe(it.sel);
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s %s: actual=%0h expected=%0h", it.req, it.sel.name(), act, it.exp);
        end
      end
    end
  end

  task automatic expect_val(string req, sel_t s, int e);
    item_t it;
    it.req = req; it.sel = s; it.exp = e;
    q.push_back(it);
  endtask

  task automatic judge();
    #1;
    -> go;
    while (q.size() != 0) #1;
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cpu_write(logic [W-1:0] d);
    cpu_wdata = d; cpu_wr_out = 1'b1;
    tick(1);
    cpu_wr_out = 1'b0;
  endtask

  task automatic cpu_read();
    cpu_rd_in = 1'b1;
    tick(1);
    cpu_rd_in = 1'b0;
  endtask

  task automatic pulse_clr();
    stat_clr = 1'b1;
    tick(1);
    stat_clr = 1'b0;
  endtask

  // collide: 0 none, 1 cpu read on the closing edge, 2 clear on the closing edge
  task automatic host_write(logic [W-1:0] d, int collide);
    ext_data_i = d; ext_cs_n = 1'b0; ext_wr_n = 1'b0;
    tick(4);
    ext_cs_n = 1'b1; ext_wr_n = 1'b1;
    if (collide != 0) begin
      @(posedge clk); @(posedge clk); @(negedge clk);
      if (collide == 1) cpu_rd_in = 1'b1; else stat_clr = 1'b1;
      @(negedge clk);
      cpu_rd_in = 1'b0; stat_clr = 1'b0;
      tick(3);
    end else begin
      tick(5);
    end
  endtask

  task automatic host_read_open();
    ext_cs_n = 1'b0; ext_rd_n = 1'b0;
  endtask

  task automatic host_read_close(bit clr_on_close);
    ext_rd_n = 1'b1;
    if (clr_on_close) begin
      @(posedge clk); @(posedge clk); @(negedge clk);
      stat_clr = 1'b1;
      @(negedge clk);
      stat_clr = 1'b0;
      tick(3);
    end else begin
      tick(5);
    end
    ext_cs_n = 1'b1;
    tick(3);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; port_en = 1'b0;
    ext_cs_n = 1'b1; ext_rd_n = 1'b1; ext_wr_n = 1'b1;
    ext_data_i = '0; cpu_wdata = '0;
    cpu_wr_out = 1'b0; cpu_rd_in = 1'b0; stat_clr = 1'b0;
    tick(4);
    rst = 1'b0;
    tick(1);

    // R1 reset state
    expect_val("R1", S_OE, 0);   expect_val("R1", S_INF, 0);
    expect_val("R1", S_OUTF, 0); expect_val("R1", S_OVR, 0);
    expect_val("R1", S_IRQ, 0);  expect_val("R1", S_RDATA, 0);
    expect_val("R1", S_DOUT, 0);
    judge();

    // R2 port disabled: host strobes ignored
    host_write(8'h5A, 0);
    expect_val("R2", S_INF, 0); expect_val("R2", S_IRQ, 0);
    expect_val("R2", S_RDATA, 0);
    judge();
    host_read_open(); tick(5);
    expect_val("R2", S_OE, 0);
    judge();
    host_read_close(0);
    expect_val("R2", S_IRQ, 0);
    judge();

    port_en = 1'b1;
    tick(2);

    // R5 local write loads outbound latch
    cpu_write(8'hC3);
    expect_val("R5", S_OUTF, 1); expect_val("R5", S_DOUT, 8'hC3);
    judge();

    // R4 read timing through synchronizer
    host_read_open();
    tick(2);
    expect_val("R4", S_OE, 0);
    judge();
    tick(1);
    expect_val("R4", S_OE, 1); expect_val("R4", S_DOUT, 8'hC3);
    judge();
    tick(2);
    // R9 read close
    host_read_close(0);
    expect_val("R9", S_OE, 0); expect_val("R9", S_OUTF, 0);
    expect_val("R9", S_IRQ, 1);
    judge();

    // R10 clear
    pulse_clr();
    expect_val("R10", S_IRQ, 0);
    judge();

    // R6 local write during host read
    host_read_open();
    tick(4);
    cpu_write(8'h3C);
    expect_val("R6", S_DOUT, 8'h3C); expect_val("R6", S_OE, 1);
    expect_val("R6", S_OUTF, 0);
    judge();
    host_read_close(0);
    pulse_clr();

    // R3 host write
    host_write(8'hA5, 0);
    expect_val("R3", S_RDATA, 8'hA5); expect_val("R3", S_INF, 1);
    expect_val("R3", S_IRQ, 1);       expect_val("R3", S_OVR, 0);
    judge();

    // R7 local read clears in_full
    cpu_read();
    expect_val("R7", S_INF, 0); expect_val("R7", S_RDATA, 8'hA5);
    judge();

    // R8 overrun
    host_write(8'h11, 0);
    expect_val("R8", S_OVR, 0);
    judge();
    host_write(8'h22, 0);
    expect_val("R8", S_OVR, 1); expect_val("R8", S_RDATA, 8'h22);
    judge();
    pulse_clr();
    expect_val("R10", S_OVR, 0); expect_val("R10", S_IRQ, 0);
    judge();

    // R8 collision: write close and local read on the same edge
    host_write(8'h33, 1);
    expect_val("R8", S_INF, 1); expect_val("R8", S_OVR, 0);
    expect_val("R8", S_RDATA, 8'h33);
    judge();

    // R10 collision: clear on the same edge as a write close
    pulse_clr();
    cpu_read();
    host_write(8'h44, 2);
    expect_val("R10", S_IRQ, 1); expect_val("R10", S_RDATA, 8'h44);
    judge();

    // R10 collision: clear on the same edge as a read close
    pulse_clr();
    expect_val("R10", S_IRQ, 0);
    judge();
    host_read_open(); tick(4);
    host_read_close(1);
    expect_val("R10", S_IRQ, 1); expect_val("R9", S_OE, 0);
    judge();

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule